// File: doc/BRIEF.md
# Character LCD Bridge on a Shared SRAM Bus

This block lets an 8-bit Wishbone host reach a character LCD panel whose data, register-select and read/write lines are wired onto the same board bus as two 8-bit SRAM banks. A separate memory controller normally owns that bus. Its address, active-low chip enable, per-bank write and output enables, and per-bank data flow through the block unchanged. When the host raises a cycle (STB and CYC both high), the block deselects the memory. It then borrows the two lowest address pins and bank 0's data pins for the panel, and it times an enable pulse on a dedicated LCD enable line.

The data buses are presented as split pad signals: an output value, an output enable and an input value for each bank. The tri-state pads sit outside the block. The host side has a 1-bit address that selects the panel register, with 0 for the instruction/control register and 1 for the data register. A transfer ends with a one-cycle acknowledge.

The host access runs through the states IDLE, SETUP, PULSE, HOLD and DONE. In IDLE, a host request moves the machine to SETUP. SETUP lasts `SETUP_CYC` cycles and then moves to PULSE, where the enable is high for `PULSE_CYC` cycles. PULSE moves to HOLD for `HOLD_CYC` cycles. HOLD moves to DONE, where ACK is high for one cycle, and DONE returns to IDLE.

Top module: `lcd_mem_bridge`

## Requirements
- R1: `mem_cs_n` is high whenever `wb_stb` and `wb_cyc` are both high. Otherwise it equals `mc_ce_n`.
- R2: With no host cycle active, `mem_addr` equals `mc_addr` on all 17 bits.
- R3: During a host cycle, `mem_addr[16:2]` follows `mc_addr[16:2]`. `mem_addr[1]` carries `wb_we` (1 = write) and `mem_addr[0]` carries `wb_adr` (0 = instruction register, 1 = data register).
- R4: `mem_we_n` and `mem_oe_n` always equal `mc_we_n` and `mc_oe_n`, bit for bit, with bit 0 for bank 0 and bit 1 for bank 1.
- R5: Bank 1 data always passes through: `mem1_dout` = `mc1_wdata`, `mem1_doe` = NOT `mc_we_n[1]`, and `mc1_rdata` = `mem1_din`. Bank 0 does the same with `mc_we_n[0]` while no host cycle is active, and `mc0_rdata` always equals `mem0_din`.
- R6: On an LCD write, `mem0_doe` is high and `mem0_dout` equals `wb_dat_w` through SETUP, PULSE and HOLD. `mem0_doe` is low in IDLE and DONE during the host cycle.
- R7: `lcd_en` goes high `SETUP_CYC` + 1 clock edges after the request is first seen. It stays high for exactly `PULSE_CYC` cycles.
- R8: `wb_ack` is high for exactly one cycle, `SETUP_CYC`+`PULSE_CYC`+`HOLD_CYC`+1 edges after the request. This is after `lcd_en` has fallen.
- R9: On an LCD read, `mem0_doe` stays low. `wb_dat_r` returns the `mem0_din` value present in the last cycle of the enable pulse and holds it after the access.
- R10: A synchronous active-high `rst` returns the block to IDLE, with `lcd_en` low, `wb_ack` low, `mem0_doe` released and `wb_dat_r` cleared to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wb_cyc | input | 1 | Wishbone cycle |
| wb_stb | input | 1 | Wishbone strobe |
| wb_we | input | 1 | Wishbone write enable (1 = write) |
| wb_adr | input | 1 | Panel register select (0 = instruction, 1 = data) |
| wb_dat_w | input | 8 | Host write data |
| wb_dat_r | output | 8 | Host read data |
| wb_ack | output | 1 | Transfer acknowledge |
| mc_ce_n | input | 1 | Controller chip enable, active low |
| mc_addr | input | 17 | Controller address |
| mc_we_n | input | 2 | Controller write enables per bank, active low |
| mc_oe_n | input | 2 | Controller output enables per bank, active low |
| mc0_wdata | input | 8 | Controller write data, bank 0 |
| mc0_rdata | output | 8 | Read data to controller, bank 0 |
| mc1_wdata | input | 8 | Controller write data, bank 1 |
| mc1_rdata | output | 8 | Read data to controller, bank 1 |
| mem_cs_n | output | 1 | Shared memory chip select, active low |
| mem_addr | output | 17 | Shared address pins |
| mem_we_n | output | 2 | Bank write enables, active low |
| mem_oe_n | output | 2 | Bank output enables, active low |
| mem0_dout | output | 8 | Bank 0 pad output value |
| mem0_doe | output | 1 | Bank 0 pad output enable |
| mem0_din | input | 8 | Bank 0 pad input value |
| mem1_dout | output | 8 | Bank 1 pad output value |
| mem1_doe | output | 1 | Bank 1 pad output enable |
| mem1_din | input | 8 | Bank 1 pad input value |
| lcd_en | output | 1 | LCD enable pulse |

## Verification
The read capture is the hardest case to reach from the ports. The panel value only has to be valid in the last enable cycle, so a design that samples one cycle early or late returns the wrong byte only if the pad input changes around that edge. The bench therefore watches `lcd_en` at every falling clock edge. It drives the expected byte on `mem0_din` only while the enable is high and switches to a different byte as soon as the enable drops. It also times the enable edges and the acknowledge against the three phase lengths, counting cycles from the request.

// File: rtl/lcdb_pkg.sv
package lcdb_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_SETUP = 3'd1,
        ST_PULSE = 3'd2,
        ST_HOLD  = 3'd3,
        ST_DONE  = 3'd4
    } lcdb_state_e;
endpackage

// File: rtl/lcdb_fsm.sv
// Host access sequencer: setup, enable pulse, hold, acknowledge.
module lcdb_fsm
    import lcdb_pkg::*;
#(
    parameter int DW        = 8,
    parameter int SETUP_CYC = 2,
    parameter int PULSE_CYC = 4,
    parameter int HOLD_CYC  = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          host_req,
    input  logic          host_we,
    input  logic [DW-1:0] rd_in,
    output logic          lcd_en,
    output logic          ack,
    output logic          drive_wr,
    output logic [DW-1:0] rd_q
);
    localparam int MAXC = (SETUP_CYC > PULSE_CYC)
                        ? ((SETUP_CYC > HOLD_CYC) ? SETUP_CYC : HOLD_CYC)
                        : ((PULSE_CYC > HOLD_CYC) ? PULSE_CYC : HOLD_CYC);
    localparam int CW = (MAXC > 1) ? $clog2(MAXC) : 1;

    lcdb_state_e state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          last_cyc;

    assign last_cyc = (cnt_q == '0);

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            rd_q    <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            if (state_q == ST_PULSE && last_cyc && !host_we)
                rd_q <= rd_in;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (host_req) begin
                    state_d = ST_SETUP;
                    cnt_d   = CW'(SETUP_CYC - 1);
                end
            end
            ST_SETUP: begin
                if (last_cyc) begin
                    state_d = ST_PULSE;
                    cnt_d   = CW'(PULSE_CYC - 1);
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            ST_PULSE: begin
                if (last_cyc) begin
                    state_d = ST_HOLD;
                    cnt_d   = CW'(HOLD_CYC - 1);
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            ST_HOLD: begin
                if (last_cyc) state_d = ST_DONE;
                else          cnt_d   = cnt_q - 1'b1;
            end
            ST_DONE: begin
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs from state
    always_comb begin
        lcd_en   = 1'b0;
        ack      = 1'b0;
        drive_wr = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_SETUP: drive_wr = host_we;
            ST_PULSE: begin
                lcd_en   = 1'b1;
                drive_wr = host_we;
            end
            ST_HOLD:  drive_wr = host_we;
            ST_DONE:  ack = 1'b1;
            default:  ;
        endcase
    end
endmodule

// File: rtl/lcdb_pinmux.sv
// Shared-pin steering between the memory controller and the LCD access.
module lcdb_pinmux #(
    parameter int DW = 8,
    parameter int AW = 17,
    parameter int NB = 2
) (
    input  logic                   host_act,
    input  logic                   host_we,
    input  logic                   host_adr,
    input  logic [DW-1:0]          host_wdata,
    input  logic                   lcd_drive,
    input  logic                   mc_ce_n,
    input  logic [AW-1:0]          mc_addr,
    input  logic [NB-1:0]          mc_we_n,
    input  logic [NB-1:0]          mc_oe_n,
    input  logic [NB-1:0][DW-1:0]  mc_wdata,
    output logic [NB-1:0][DW-1:0]  mc_rdata,
    output logic                   mem_cs_n,
    output logic [AW-1:0]          mem_addr,
    output logic [NB-1:0]          mem_we_n,
    output logic [NB-1:0]          mem_oe_n,
    output logic [NB-1:0][DW-1:0]  mem_dout,
    output logic [NB-1:0]          mem_doe,
    input  logic [NB-1:0][DW-1:0]  mem_din
);
    assign mem_cs_n = mc_ce_n | host_act;
    assign mem_addr = host_act ? {mc_addr[AW-1:2], host_we, host_adr} : mc_addr;
    assign mem_we_n = mc_we_n;
    assign mem_oe_n = mc_oe_n;

    for (genvar b = 0; b < NB; b++) begin : g_bank
        assign mc_rdata[b] = mem_din[b];
        if (b == 0) begin : g_lcd
            assign mem_dout[b] = host_act ? host_wdata : mc_wdata[b];
            assign mem_doe[b]  = host_act ? lcd_drive  : ~mc_we_n[b];
        end else begin : g_mem
            assign mem_dout[b] = mc_wdata[b];
            assign mem_doe[b]  = ~mc_we_n[b];
        end
    end
endmodule

// File: rtl/lcd_mem_bridge.sv
module lcd_mem_bridge #(
    parameter int SETUP_CYC = 2,
    parameter int PULSE_CYC = 4,
    parameter int HOLD_CYC  = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wb_cyc,
    input  logic        wb_stb,
    input  logic        wb_we,
    input  logic        wb_adr,
    input  logic [7:0]  wb_dat_w,
    output logic [7:0]  wb_dat_r,
    output logic        wb_ack,
    input  logic        mc_ce_n,
    input  logic [16:0] mc_addr,
    input  logic [1:0]  mc_we_n,
    input  logic [1:0]  mc_oe_n,
    input  logic [7:0]  mc0_wdata,
    output logic [7:0]  mc0_rdata,
    input  logic [7:0]  mc1_wdata,
    output logic [7:0]  mc1_rdata,
    output logic        mem_cs_n,
    output logic [16:0] mem_addr,
    output logic [1:0]  mem_we_n,
    output logic [1:0]  mem_oe_n,
    output logic [7:0]  mem0_dout,
    output logic        mem0_doe,
    input  logic [7:0]  mem0_din,
    output logic [7:0]  mem1_dout,
    output logic        mem1_doe,
    input  logic [7:0]  mem1_din,
    output logic        lcd_en
);
    localparam int DW = 8;
    localparam int AW = 17;
    localparam int NB = 2;

    logic                  host_act;
    logic                  drive_wr;
    logic [NB-1:0][DW-1:0] mc_wd, mc_rd, m_dout, m_din;
    logic [NB-1:0]         m_doe;

    assign host_act = wb_stb & wb_cyc;
    assign mc_wd    = {mc1_wdata, mc0_wdata};
    assign m_din    = {mem1_din, mem0_din};
    assign mc0_rdata = mc_rd[0];
    assign mc1_rdata = mc_rd[1];
    assign mem0_dout = m_dout[0];
    assign mem1_dout = m_dout[1];
    assign mem0_doe  = m_doe[0];
    assign mem1_doe  = m_doe[1];

    lcdb_fsm #(
        .DW(DW), .SETUP_CYC(SETUP_CYC), .PULSE_CYC(PULSE_CYC), .HOLD_CYC(HOLD_CYC)
    ) u_fsm (
        .clk(clk), .rst(rst), .host_req(host_act), .host_we(wb_we),
        .rd_in(mem0_din), .lcd_en(lcd_en), .ack(wb_ack),
        .drive_wr(drive_wr), .rd_q(wb_dat_r)
    );

    lcdb_pinmux #(.DW(DW), .AW(AW), .NB(NB)) u_mux (
        .host_act(host_act), .host_we(wb_we), .host_adr(wb_adr),
        .host_wdata(wb_dat_w), .lcd_drive(drive_wr),
        .mc_ce_n(mc_ce_n), .mc_addr(mc_addr), .mc_we_n(mc_we_n),
        .mc_oe_n(mc_oe_n), .mc_wdata(mc_wd), .mc_rdata(mc_rd),
        .mem_cs_n(mem_cs_n), .mem_addr(mem_addr), .mem_we_n(mem_we_n),
        .mem_oe_n(mem_oe_n), .mem_dout(m_dout), .mem_doe(m_doe), .mem_din(m_din)
    );
endmodule

// File: rtl/lcdb_checker.sv
module lcdb_checker (
    input logic        clk,
    input logic        rst,
    input logic        wb_cyc,
    input logic        wb_stb,
    input logic        wb_we,
    input logic [7:0]  wb_dat_w,
    input logic        wb_ack,
    input logic [1:0]  mc_we_n,
    input logic        mem_cs_n,
    input logic [1:0]  mem_we_n,
    input logic [7:0]  mem0_dout,
    input logic        mem0_doe,
    input logic        lcd_en
);
    // R1
    cs_off_chk: assert property (@(posedge clk) disable iff (rst)
        (wb_stb && wb_cyc) |-> mem_cs_n);
    // R4
    we_follow_chk: assert property (@(posedge clk) disable iff (rst)
        mem_we_n == mc_we_n);
    // R6
    wr_drive_chk: assert property (@(posedge clk) disable iff (rst)
        (lcd_en && wb_we) |-> (mem0_doe && mem0_dout == wb_dat_w));
    // R9
    rd_release_chk: assert property (@(posedge clk) disable iff (rst)
        (lcd_en && !wb_we) |-> !mem0_doe);
    // R8
    ack_single_chk: assert property (@(posedge clk) disable iff (rst)
        wb_ack |=> !wb_ack);
    // R8
    ack_no_en_chk: assert property (@(posedge clk) disable iff (rst)
        wb_ack |-> !lcd_en);
    // R10
    reset_idle_chk: assert property (@(posedge clk)
        rst |=> (!lcd_en && !wb_ack));
endmodule

bind lcd_mem_bridge lcdb_checker u_chk (
    .clk(clk), .rst(rst), .wb_cyc(wb_cyc), .wb_stb(wb_stb), .wb_we(wb_we),
    .wb_dat_w(wb_dat_w), .wb_ack(wb_ack), .mc_we_n(mc_we_n),
    .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n), .mem0_dout(mem0_dout),
    .mem0_doe(mem0_doe), .lcd_en(lcd_en)
);

// File: tb/lcd_mem_bridge_test.sv
module lcd_mem_bridge_test;
    localparam int S = 2;
    localparam int P = 4;
    localparam int H = 2;

    logic        clk = 1'b0;
    logic        rst;
    logic        wb_cyc, wb_stb, wb_we, wb_adr;
    logic [7:0]  wb_dat_w, wb_dat_r;
    logic        wb_ack;
    logic        mc_ce_n;
    logic [16:0] mc_addr;
    logic [1:0]  mc_we_n, mc_oe_n;
    logic [7:0]  mc0_wdata, mc0_rdata, mc1_wdata, mc1_rdata;
    logic        mem_cs_n;
    logic [16:0] mem_addr;
    logic [1:0]  mem_we_n, mem_oe_n;
    logic [7:0]  mem0_dout, mem0_din, mem1_dout, mem1_din;
    logic        mem0_doe, mem1_doe, lcd_en;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    lcd_mem_bridge #(.SETUP_CYC(S), .PULSE_CYC(P), .HOLD_CYC(H)) uut (
        .clk(clk), .rst(rst), .wb_cyc(wb_cyc), .wb_stb(wb_stb), .wb_we(wb_we),
        .wb_adr(wb_adr), .wb_dat_w(wb_dat_w), .wb_dat_r(wb_dat_r), .wb_ack(wb_ack),
        .mc_ce_n(mc_ce_n), .mc_addr(mc_addr), .mc_we_n(mc_we_n), .mc_oe_n(mc_oe_n),
        .mc0_wdata(mc0_wdata), .mc0_rdata(mc0_rdata),
        .mc1_wdata(mc1_wdata), .mc1_rdata(mc1_rdata),
        .mem_cs_n(mem_cs_n), .mem_addr(mem_addr), .mem_we_n(mem_we_n),
        .mem_oe_n(mem_oe_n), .mem0_dout(mem0_dout), .mem0_doe(mem0_doe),
        .mem0_din(mem0_din), .mem1_dout(mem1_dout), .mem1_doe(mem1_doe),
        .mem1_din(mem1_din), .lcd_en(lcd_en)
    );

    typedef struct packed {
        logic        ce_n;
        logic [16:0] addr;
        logic [1:0]  we_n;
        logic [1:0]  oe_n;
        logic        stb;
        logic        cyc;
        logic        we;
        logic        adr;
        logic        exp_cs_n;
        logic [16:0] exp_addr;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{1'b0, 17'h1ABCD, 2'b10, 2'b01, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 17'h1ABCD},
        '{1'b1, 17'h00003, 2'b01, 2'b10, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 17'h00003},
        '{1'b0, 17'h0F0F0, 2'b11, 2'b00, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 17'h0F0F0},
        '{1'b0, 17'h15555, 2'b00, 2'b11, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 17'h15555},
        '{1'b0, 17'h1FFFF, 2'b10, 2'b11, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 17'h1FFFE},
        '{1'b1, 17'h00000, 2'b11, 2'b01, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 17'h00001},
        '{1'b0, 17'h0AAA8, 2'b01, 2'b00, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 17'h0AAAB},
        '{1'b0, 17'h0AAAB, 2'b11, 2'b10, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 17'h0AAA8}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        wb_stb = 1'b0;
        wb_cyc = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    // One LCD access; cycles counted at falling edges after the request.
    task automatic lcd_access(input logic we, input logic adr, input logic [7:0] wd,
                              input logic [7:0] rv);
        int n = 0;
        int en_cnt = 0;
        int en_first = 0;
        int ack_at = 0;
        int ack_cnt = 0;
        logic doe_bad = 1'b0;
        @(negedge clk);
        wb_stb = 1'b1; wb_cyc = 1'b1; wb_we = we; wb_adr = adr; wb_dat_w = wd;
        mem0_din = ~rv;
        while (ack_at == 0 && n < 100) begin
            @(negedge clk);
            n++;
            if (lcd_en) begin
                en_cnt++;
                if (en_first == 0) en_first = n;
                mem0_din = rv;
            end else begin
                mem0_din = ~rv;
            end
            if (n <= S + P + H && mem0_doe !== we) doe_bad = 1'b1;
            if (we && mem0_doe && mem0_dout !== wd) doe_bad = 1'b1;
            if (wb_ack) begin
                ack_at = n;
                ack_cnt++;
                if (mem0_doe !== 1'b0) doe_bad = 1'b1;
            end
        end
        if (ack_at == 0) begin
            fails++;
            $display("FAIL R8: no acknowledge");
        end
        wb_stb = 1'b0; wb_cyc = 1'b0;
        check("R7 enable start", 32'(en_first), 32'(S + 1));
        check("R7 enable width", 32'(en_cnt), 32'(P));
        check("R8 ack cycle", 32'(ack_at), 32'(S + P + H + 1));
        if (we) check("R6 bank0 drive window", 32'(doe_bad), 32'd0);
        else    check("R9 bank0 released", 32'(doe_bad), 32'd0);
        @(negedge clk);
        check("R8 ack one cycle", 32'(wb_ack), 32'd0);
        if (!we) check("R9 read data held", 32'(wb_dat_r), 32'(rv));
    endtask

    initial begin
        #(10 * 150000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks + 1 - fails, checks + 1);
        $finish;
    end

    initial begin
        rst = 1'b1;
        wb_cyc = 1'b0; wb_stb = 1'b0; wb_we = 1'b0; wb_adr = 1'b0; wb_dat_w = 8'h00;
        mc_ce_n = 1'b1; mc_addr = '0; mc_we_n = 2'b11; mc_oe_n = 2'b11;
        mc0_wdata = 8'h00; mc1_wdata = 8'h00; mem0_din = 8'h00; mem1_din = 8'h00;
        repeat (3) @(negedge clk);
        // R10 reset state
        check("R10 lcd_en", 32'(lcd_en), 32'd0);
        check("R10 ack", 32'(wb_ack), 32'd0);
        check("R10 bank0 release", 32'(mem0_doe), 32'd0);
        check("R10 read data", 32'(wb_dat_r), 32'd0);
        rst = 1'b0;

        // table walk: R1, R2, R3, R4
        foreach (VECS[i]) begin
            @(negedge clk);
            mc_ce_n = VECS[i].ce_n; mc_addr = VECS[i].addr;
            mc_we_n = VECS[i].we_n; mc_oe_n = VECS[i].oe_n;
            wb_stb = VECS[i].stb; wb_cyc = VECS[i].cyc;
            wb_we = VECS[i].we; wb_adr = VECS[i].adr;
            #1;
            check("R1 chip select", 32'(mem_cs_n), 32'(VECS[i].exp_cs_n));
            check((VECS[i].stb && VECS[i].cyc) ? "R3 lcd address" : "R2 address pass",
                  32'(mem_addr), 32'(VECS[i].exp_addr));
            check("R4 write enables", 32'(mem_we_n), 32'(VECS[i].we_n));
            check("R4 output enables", 32'(mem_oe_n), 32'(VECS[i].oe_n));
            if (VECS[i].stb && VECS[i].cyc) do_reset();
        end
        wb_stb = 1'b0; wb_cyc = 1'b0;

        // R5 data pass-through, no host cycle
        @(negedge clk);
        mc_we_n = 2'b10; mc0_wdata = 8'h3C; mc1_wdata = 8'hC3;
        mem0_din = 8'h5A; mem1_din = 8'hA5;
        #1;
        check("R5 bank0 doe", 32'(mem0_doe), 32'd1);
        check("R5 bank0 dout", 32'(mem0_dout), 32'h3C);
        check("R5 bank1 doe", 32'(mem1_doe), 32'd0);
        check("R5 bank0 rdata", 32'(mc0_rdata), 32'h5A);
        check("R5 bank1 rdata", 32'(mc1_rdata), 32'hA5);
        mc_we_n = 2'b01;
        #1;
        check("R5 bank1 doe", 32'(mem1_doe), 32'd1);
        check("R5 bank1 dout", 32'(mem1_dout), 32'hC3);
        check("R5 bank0 doe off", 32'(mem0_doe), 32'd0);
        mc_we_n = 2'b11;

        // LCD transfers: R6 writes, R9 reads, R7/R8 timing
        lcd_access(1'b1, 1'b0, 8'h38, 8'h00);
        lcd_access(1'b1, 1'b1, 8'hC7, 8'h00);
        lcd_access(1'b0, 1'b1, 8'h00, 8'h96);
        lcd_access(1'b0, 1'b0, 8'h00, 8'h81);

        // R6 bank0 released in IDLE/DONE even if controller writes bank 0
        @(negedge clk);
        mc_we_n = 2'b10;
        wb_stb = 1'b1; wb_cyc = 1'b1; wb_we = 1'b1;
        #1;
        check("R6 no drive in idle", 32'(mem0_doe), 32'd0);
        check("R1 cs forced off", 32'(mem_cs_n), 32'd1);
        // R10 reset mid-access
        @(negedge clk);
        @(negedge clk);
        rst = 1'b1; wb_stb = 1'b0; wb_cyc = 1'b0; mc_we_n = 2'b11;
        @(negedge clk);
        rst = 1'b0;
        check("R10 mid-access lcd_en", 32'(lcd_en), 32'd0);
        check("R10 mid-access ack", 32'(wb_ack), 32'd0);
        check("R10 mid-access release", 32'(mem0_doe), 32'd0);
        repeat (S + P + H + 2) begin
            @(negedge clk);
            if (lcd_en || wb_ack) begin
                fails++;
                $display("FAIL R10: actual activity after reset expected idle");
            end
        end
        checks++;

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule